// File: doc/BRIEF.md
# Coprocessor Slave Bus Interface

This block is the coprocessor end of a shared 16-bit bus on which a host processor hands instructions to an attached arithmetic unit. Every host bus cycle carries a four-bit cycle tag. The block stays silent until it sees its own identification byte in a write tagged 4'b1111. It then takes an operation word that arrives with its two bytes swapped and restores the natural byte order. From that word it works out how many operands to take, how wide they are, and whether a result goes back to the host.

After the last operand word it hands the opcode, the type and both source operands to an external execution unit over a ready/valid request. It waits on a ready/valid response. When the response arrives it drives an active-low completion strobe for one cycle. It then offers a status word in a read tagged 4'b1110. If the instruction returns a value and no error was reported, it also offers the result in reads tagged 4'b1101. Compare instructions return condition flags in the status word and no result. An undefined type code is refused: the block skips the execution unit and goes straight to the completion strobe with the quit bit set.

Top module: `cpsb_slave_if`

## Requirements
- R1: The block leaves idle only on a write tagged 4'b1111 whose low byte equals SLAVE_ID. A write with a different byte, or with any other tag, leaves it idle: no request and no completion pulse follow, even if an operation word comes next.
- R2: The operation word is written with tag 4'b1101. Its natural bits [7:0] arrive on bus lines [15:8] and natural bits [15:8] on lines [7:0]. After the bytes are swapped back, bits [3:0] are the opcode and bits [5:4] are the type. The request carries both fields.
- R3: Opcodes 0 to 3 (add, subtract, multiply, divide) take two operands and return a result on the bus.
- R4: Opcodes 4 to 10 (move, absolute, negate, floor, truncate, round, convert) take one operand and return a result. The second source is zero.
- R5: Opcode 11 (compare) takes two operands and returns no result. The response flags {N,Z,L} appear in status bits 7, 6 and 2. These bits read as zero for every other opcode.
- R6: Opcodes 12 and 13 (polynomial, dot product) take two operands. Their result stays in a fixed coprocessor register, so no result is read on the bus.
- R7: Opcode 14 (load status register) takes one 32-bit operand and returns nothing. Opcode 15 (store status register) takes no operand and returns one 32-bit value. Both ignore the type.
- R8: Type 0 (single) and type 2 (integer doubleword) use 32-bit values carried in 2 words. Type 1 (double) uses 64-bit values carried in 4 words. Words go least significant first, operand 1 before operand 2. Unused upper bits of a source are zero.
- R9: Type 3 is undefined. The completion strobe goes low in the cycle after the operation word, with no operand, no request and no result. The status then reads 1 in bit 0 (quit).
- R10: The request is held, with a stable payload, until the unit is ready. A response with its error bit set sets quit and suppresses the result.
- R11: The completion strobe goes low for exactly one cycle, in the cycle after the response is accepted. The following read tagged 4'b1110 returns the status word, with bit 0 as quit.
- R12: Read data is zero outside a status read in the status phase or a result read in the result phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tag | input | 4 | Cycle tag of the current host bus cycle |
| bus_wr | input | 1 | Host write strobe, one cycle per word |
| bus_rd | input | 1 | Host read strobe, one cycle per word |
| bus_wdata | input | BUS_W | Host write data |
| bus_rdata | output | BUS_W | Data returned to the host |
| done_n | output | 1 | Active-low completion strobe |
| exu_req_valid | output | 1 | Request to the execution unit is valid |
| exu_req_ready | input | 1 | Execution unit accepts the request |
| exu_op | output | 4 | Opcode of the request |
| exu_type | output | 2 | Type of the request |
| exu_src_a | output | DBL_W | First source operand |
| exu_src_b | output | DBL_W | Second source operand |
| exu_rsp_valid | input | 1 | Response from the execution unit is valid |
| exu_rsp_ready | output | 1 | Block accepts the response |
| exu_rsp_data | input | DBL_W | Result value |
| exu_rsp_flags | input | 3 | Condition flags {N,Z,L} |
| exu_rsp_err | input | 1 | Execution error |

## Verification
The bench builds the block with its defaults: a 16-bit bus, 32-bit single values and 64-bit double values. With these settings every operand and result takes either two or four bus words, and the operand buffer is filled up to its eight-word limit by two-operand double instructions. Every opcode is driven under every defined type and under the undefined type. Random instructions add varied unit latencies and occasional error responses. This covers the one-word-early and one-word-late edges of operand and result counting, as well as the quit paths.

// File: rtl/cpsb_pkg.sv
package cpsb_pkg;

   typedef enum logic [3:0] {
      OPC_ADD, OPC_SUB, OPC_MUL, OPC_DIV,
      OPC_MOV, OPC_ABS, OPC_NEG, OPC_FLOOR,
      OPC_TRUNC, OPC_ROUND, OPC_CONV, OPC_CMP,
      OPC_POLY, OPC_DOT, OPC_LDSR, OPC_STSR
   } opc_e;

   localparam logic [1:0] TYP_SGL  = 2'd0;
   localparam logic [1:0] TYP_DBL  = 2'd1;
   localparam logic [1:0] TYP_INT  = 2'd2;
   localparam logic [1:0] TYP_BAD  = 2'd3;

   localparam logic [3:0] TAG_ID   = 4'b1111;
   localparam logic [3:0] TAG_XFER = 4'b1101;
   localparam logic [3:0] TAG_STAT = 4'b1110;

   localparam int ST_Q_BIT = 0;
   localparam int ST_L_BIT = 2;
   localparam int ST_Z_BIT = 6;
   localparam int ST_N_BIT = 7;

   typedef enum logic [2:0] {
      PH_IDLE, PH_OPW, PH_OPND, PH_REQ,
      PH_WAIT, PH_PULSE, PH_STAT, PH_RES
   } phase_e;

endpackage

// File: rtl/cpsb_opdecode.sv
module cpsb_opdecode
   import cpsb_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int SGL_WORDS = 2,
   parameter int DBL_WORDS = 4,
   parameter int CNT_W     = 4
) (
   input  logic [BUS_W-1:0] raw,
   output logic [3:0]       opc,
   output logic [1:0]       typ,
   output logic [CNT_W-1:0] in_words,
   output logic [CNT_W-1:0] res_words,
   output logic             has_res,
   output logic             is_cmp,
   output logic             undef
);
   localparam int HALF = BUS_W / 2;

   logic [BUS_W-1:0] nat;
   logic [1:0]       n_opnd;
   logic [CNT_W-1:0] per_opnd;

   assign nat = {raw[HALF-1:0], raw[BUS_W-1:HALF]};
   assign opc = nat[3:0];
   assign typ = nat[5:4];

   always_comb begin
      undef    = (typ == TYP_BAD);
      is_cmp   = 1'b0;
      has_res  = 1'b0;
      n_opnd   = 2'd0;
      per_opnd = (typ == TYP_DBL) ? CNT_W'(DBL_WORDS) : CNT_W'(SGL_WORDS);
      unique case (opc_e'(opc))
         OPC_ADD, OPC_SUB, OPC_MUL, OPC_DIV: begin
            n_opnd  = 2'd2;
            has_res = 1'b1;
         end
         OPC_MOV, OPC_ABS, OPC_NEG, OPC_FLOOR,
         OPC_TRUNC, OPC_ROUND, OPC_CONV: begin
            n_opnd  = 2'd1;
            has_res = 1'b1;
         end
         OPC_CMP: begin
            n_opnd = 2'd2;
            is_cmp = 1'b1;
         end
         OPC_POLY, OPC_DOT: n_opnd = 2'd2;
         OPC_LDSR: begin
            n_opnd   = 2'd1;
            per_opnd = CNT_W'(SGL_WORDS);
         end
         OPC_STSR: begin
            per_opnd = CNT_W'(SGL_WORDS);
            has_res  = 1'b1;
         end
         default: n_opnd = 2'd0;
      endcase
      if (undef) begin
         n_opnd  = 2'd0;
         has_res = 1'b0;
         is_cmp  = 1'b0;
      end
      unique case (n_opnd)
         2'd1:    in_words = per_opnd;
         2'd2:    in_words = per_opnd << 1;
         default: in_words = '0;
      endcase
      res_words = has_res ? per_opnd : '0;
   end

   // r9: an undefined word never asks for operands or a result
   always_comb begin
      if (undef) a_undef_empty_r9: assert (in_words == '0 && !has_res);
   end

endmodule

// File: rtl/cpsb_opnd_buf.sv
module cpsb_opnd_buf #(
   parameter int BUS_W     = 16,
   parameter int BUF_WORDS = 8,
   localparam int IDX_W    = $clog2(BUF_WORDS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BUS_W-1:0]           wr_data,
   output logic [BUF_WORDS*BUS_W-1:0] words
);

   for (genvar g = 0; g < BUF_WORDS; g++) begin : g_word
      logic [BUS_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (clr)                             q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))    q <= wr_data;
      end
      assign words[g*BUS_W +: BUS_W] = q;
   end

   p_idx_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < BUF_WORDS));

   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (words == '0));

endmodule

// File: rtl/cpsb_readout.sv
module cpsb_readout
   import cpsb_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int RES_WORDS = 4,
   parameter int CNT_W     = 4,
   localparam int IW       = $clog2(RES_WORDS)
) (
   input  logic                       sel_status,
   input  logic                       sel_result,
   input  logic                       quit,
   input  logic [2:0]                 flags,
   input  logic [RES_WORDS*BUS_W-1:0] result,
   input  logic [CNT_W-1:0]           idx,
   output logic [BUS_W-1:0]           rdata
);
   logic [BUS_W-1:0] res_word [RES_WORDS];
   logic [BUS_W-1:0] status;

   for (genvar g = 0; g < RES_WORDS; g++) begin : g_res
      assign res_word[g] = result[g*BUS_W +: BUS_W];
   end

   always_comb begin
      status           = '0;
      status[ST_Q_BIT] = quit;
      status[ST_N_BIT] = flags[2];
      status[ST_Z_BIT] = flags[1];
      status[ST_L_BIT] = flags[0];
   end

   always_comb begin
      if (sel_status)      rdata = status;
      else if (sel_result) rdata = res_word[idx[IW-1:0]];
      else                 rdata = '0;
   end

endmodule

// File: rtl/cpsb_slave_if.sv
module cpsb_slave_if
   import cpsb_pkg::*;
#(
   parameter int         BUS_W    = 16,
   parameter int         SGL_W    = 32,
   parameter int         DBL_W    = 64,
   parameter logic [7:0] SLAVE_ID = 8'hA6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       bus_tag,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             done_n,
   output logic             exu_req_valid,
   input  logic             exu_req_ready,
   output logic [3:0]       exu_op,
   output logic [1:0]       exu_type,
   output logic [DBL_W-1:0] exu_src_a,
   output logic [DBL_W-1:0] exu_src_b,
   input  logic             exu_rsp_valid,
   output logic             exu_rsp_ready,
   input  logic [DBL_W-1:0] exu_rsp_data,
   input  logic [2:0]       exu_rsp_flags,
   input  logic             exu_rsp_err
);
   localparam int SGL_WORDS = SGL_W / BUS_W;
   localparam int DBL_WORDS = DBL_W / BUS_W;
   localparam int BUF_WORDS = 2 * DBL_WORDS;
   localparam int CNT_W     = $clog2(BUF_WORDS + 1);
   localparam int IDX_W     = $clog2(BUF_WORDS);

   if (BUS_W < 16 || (BUS_W % 2) != 0) begin : g_bad_bus
      $error("BUS_W must be even and at least 16");
   end
   if ((SGL_W % BUS_W) != 0 || SGL_W < 2 * BUS_W) begin : g_bad_sgl
      $error("SGL_W must be a multiple of BUS_W spanning two or more words");
   end
   if (DBL_W != 2 * SGL_W) begin : g_bad_dbl
      $error("DBL_W must be twice SGL_W");
   end

   // bus cycle classification
   logic wr_id, wr_xfer, rd_stat, rd_xfer;
   assign wr_id   = bus_wr && bus_tag == TAG_ID;
   assign wr_xfer = bus_wr && bus_tag == TAG_XFER;
   assign rd_stat = bus_rd && bus_tag == TAG_STAT;
   assign rd_xfer = bus_rd && bus_tag == TAG_XFER;

   // decode of the incoming operation word
   logic [3:0]       d_opc;
   logic [1:0]       d_typ;
   logic [CNT_W-1:0] d_in_words, d_res_words;
   logic             d_has_res, d_is_cmp, d_undef;

   cpsb_opdecode #(
      .BUS_W(BUS_W), .SGL_WORDS(SGL_WORDS), .DBL_WORDS(DBL_WORDS), .CNT_W(CNT_W)
   ) u_dec (
      .raw(bus_wdata), .opc(d_opc), .typ(d_typ), .in_words(d_in_words),
      .res_words(d_res_words), .has_res(d_has_res), .is_cmp(d_is_cmp), .undef(d_undef)
   );

   // instruction state
   phase_e           phase;
   logic [3:0]       opc_q;
   logic [1:0]       typ_q;
   logic [CNT_W-1:0] in_words_q, res_words_q, cnt_q;
   logic             has_res_q, is_cmp_q, quit_q;
   logic [2:0]       flags_q;
   logic [DBL_W-1:0] res_q;

   logic opw_take, opnd_take;
   assign opw_take  = (phase == PH_OPW)  && wr_xfer;
   assign opnd_take = (phase == PH_OPND) && wr_xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         opc_q       <= '0;
         typ_q       <= '0;
         in_words_q  <= '0;
         res_words_q <= '0;
         cnt_q       <= '0;
         has_res_q   <= 1'b0;
         is_cmp_q    <= 1'b0;
         quit_q      <= 1'b0;
         flags_q     <= '0;
         res_q       <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (wr_id && bus_wdata[7:0] == SLAVE_ID) phase <= PH_OPW;
            PH_OPW: if (wr_xfer) begin
               opc_q       <= d_opc;
               typ_q       <= d_typ;
               in_words_q  <= d_in_words;
               res_words_q <= d_res_words;
               has_res_q   <= d_has_res;
               is_cmp_q    <= d_is_cmp;
               quit_q      <= d_undef;
               flags_q     <= '0;
               cnt_q       <= '0;
               if (d_undef)                 phase <= PH_PULSE;
               else if (d_in_words == '0)   phase <= PH_REQ;
               else                         phase <= PH_OPND;
            end
            PH_OPND: if (wr_xfer) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == in_words_q - 1'b1) phase <= PH_REQ;
            end
            PH_REQ: if (exu_req_ready) phase <= PH_WAIT;
            PH_WAIT: if (exu_rsp_valid) begin
               res_q   <= exu_rsp_data;
               flags_q <= is_cmp_q ? exu_rsp_flags : 3'b000;
               quit_q  <= exu_rsp_err;
               phase   <= PH_PULSE;
            end
            PH_PULSE: phase <= PH_STAT;
            PH_STAT: if (rd_stat) begin
               cnt_q <= '0;
               phase <= (has_res_q && !quit_q) ? PH_RES : PH_IDLE;
            end
            PH_RES: if (rd_xfer) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == res_words_q - 1'b1) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // operand words
   logic [BUF_WORDS*BUS_W-1:0] buf_words;

   cpsb_opnd_buf #(.BUS_W(BUS_W), .BUF_WORDS(BUF_WORDS)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(opw_take), .wr_en(opnd_take),
      .wr_idx(cnt_q[IDX_W-1:0]), .wr_data(bus_wdata), .words(buf_words)
   );

   logic wide;
   assign wide = (typ_q == TYP_DBL) && (opc_q != OPC_LDSR) && (opc_q != OPC_STSR);

   always_comb begin
      if (wide) begin
         exu_src_a = buf_words[DBL_W-1:0];
         exu_src_b = buf_words[2*DBL_W-1:DBL_W];
      end else begin
         exu_src_a = {{(DBL_W-SGL_W){1'b0}}, buf_words[SGL_W-1:0]};
         exu_src_b = {{(DBL_W-SGL_W){1'b0}}, buf_words[2*SGL_W-1:SGL_W]};
      end
   end

   assign exu_req_valid = (phase == PH_REQ);
   assign exu_rsp_ready = (phase == PH_WAIT);
   assign exu_op        = opc_q;
   assign exu_type      = typ_q;
   assign done_n        = (phase != PH_PULSE);

   cpsb_readout #(.BUS_W(BUS_W), .RES_WORDS(DBL_WORDS), .CNT_W(CNT_W)) u_rd (
      .sel_status(phase == PH_STAT && rd_stat),
      .sel_result(phase == PH_RES && rd_xfer),
      .quit(quit_q), .flags(flags_q), .result(res_q), .idx(cnt_q),
      .rdata(bus_rdata)
   );

   // assertions
   p_pulse_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done_n |=> done_n);

   p_pulse_after_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exu_rsp_valid && exu_rsp_ready) |=> !done_n);

   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exu_req_valid && !exu_req_ready) |=>
         (exu_req_valid && $stable(exu_op) && $stable(exu_src_a) && $stable(exu_src_b)));

   p_undef_skips_unit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (opw_take && d_undef) |=> (!done_n && !exu_req_valid));

   p_foreign_id_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !(wr_id && bus_wdata[7:0] == SLAVE_ID)) |=> (phase == PH_IDLE));

   p_cmp_no_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STAT && rd_stat && is_cmp_q) |=> (phase == PH_IDLE));

   p_err_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STAT && quit_q) |=> (phase != PH_RES));

endmodule

// File: tb/cpsb_slave_if_tb_top.sv
`timescale 1ns/1ps
module cpsb_slave_if_tb_top;
   localparam logic [7:0] MY_ID = 8'hA6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_tag = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        done_n;
   logic        exu_req_valid, exu_req_ready = 1'b0;
   logic [3:0]  exu_op;
   logic [1:0]  exu_type;
   logic [63:0] exu_src_a, exu_src_b;
   logic        exu_rsp_valid = 1'b0, exu_rsp_ready;
   logic [63:0] exu_rsp_data = '0;
   logic [2:0]  exu_rsp_flags = '0;
   logic        exu_rsp_err = 1'b0;

   int n_checks = 0, n_fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cpsb_slave_if #(.SLAVE_ID(MY_ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_tag(bus_tag), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_n(done_n),
      .exu_req_valid(exu_req_valid), .exu_req_ready(exu_req_ready), .exu_op(exu_op),
      .exu_type(exu_type), .exu_src_a(exu_src_a), .exu_src_b(exu_src_b),
      .exu_rsp_valid(exu_rsp_valid), .exu_rsp_ready(exu_rsp_ready),
      .exu_rsp_data(exu_rsp_data), .exu_rsp_flags(exu_rsp_flags), .exu_rsp_err(exu_rsp_err)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [3:0] tag, input logic [15:0] d);
      bus_tag = tag; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] tag, output logic [15:0] d);
      bus_tag = tag; bus_rd = 1'b1;
      #1 d = bus_rdata;
      tick();
      bus_rd = 1'b0;
   endtask

   function automatic logic [15:0] swap(input logic [15:0] x);
      return {x[7:0], x[15:8]};
   endfunction

   // expected instruction shape from the requirements
   function automatic void shape(input int opc, input int typ, output int nop, output int wpo,
                                 output bit res, output bit cmp, output bit undef);
      undef = (typ == 3);
      cmp = 0; res = 0; nop = 0;
      wpo = (opc >= 14) ? 2 : ((typ == 1) ? 4 : 2);
      if (opc <= 3)       begin nop = 2; res = 1; end        // R3
      else if (opc <= 10) begin nop = 1; res = 1; end        // R4
      else if (opc == 11) begin nop = 2; cmp = 1; end        // R5
      else if (opc <= 13) nop = 2;                           // R6
      else if (opc == 14) nop = 1;                           // R7
      else                res = 1;                           // R7
      if (undef) begin nop = 0; res = 0; cmp = 0; end        // R9
   endfunction

   function automatic logic [63:0] model(input int opc, input logic [63:0] a, input logic [63:0] b);
      return a + (b << 1) + 64'(opc);
   endfunction

   function automatic string req_of(input int opc);
      if (opc <= 3)  return "R3";
      if (opc <= 10) return "R4";
      if (opc == 11) return "R5";
      if (opc <= 13) return "R6";
      return "R7";
   endfunction

   task automatic run_instr(input int opc, input int typ, input logic [63:0] a,
                            input logic [63:0] b, input bit err);
      int nop, wpo; bit res, cmp, undef, quit;
      logic [63:0] ea, eb, data; logic [2:0] fl; logic [15:0] rd, est;
      string rq;
      shape(opc, typ, nop, wpo, res, cmp, undef);
      rq = req_of(opc);
      ea = (wpo == 4) ? a : {32'b0, a[31:0]};
      eb = (wpo == 4) ? b : {32'b0, b[31:0]};
      if (nop < 2) eb = '0;
      if (nop < 1) ea = '0;
      bus_write(4'b1111, {8'h00, MY_ID});
      bus_write(4'b1101, swap({10'b0, 2'(typ), 4'(opc)}));
      for (int k = 0; k < nop; k++)
         for (int w = 0; w < wpo; w++)
            bus_write(4'b1101, (k == 0) ? a[16*w +: 16] : b[16*w +: 16]);
      fl = 3'($urandom);
      quit = undef;
      if (undef) begin
         check(done_n == 1'b0 && exu_req_valid == 1'b0, "R9 undef pulse", {62'b0, done_n, exu_req_valid}, 64'h0);
      end else begin
         check(exu_req_valid == 1'b1, "R10 request", {63'b0, exu_req_valid}, 64'h1);
         check(exu_op == 4'(opc) && exu_type == 2'(typ), "R2 op fields", {58'b0, exu_type, exu_op}, {58'b0, 2'(typ), 4'(opc)});
         check(exu_src_a == ea, {rq, "/R8 src a"}, exu_src_a, ea);
         check(exu_src_b == eb, {rq, "/R8 src b"}, exu_src_b, eb);
         repeat ($urandom % 3) begin
            tick();
            check(exu_req_valid == 1'b1 && exu_src_a == ea && exu_src_b == eb, "R10 hold", exu_src_a, ea);
         end
         exu_req_ready = 1'b1; tick(); exu_req_ready = 1'b0;
         repeat ($urandom % 3) begin
            check(done_n == 1'b1, "R11 early pulse", {63'b0, done_n}, 64'h1);
            tick();
         end
         data = model(opc, ea, eb);
         exu_rsp_valid = 1'b1; exu_rsp_data = data; exu_rsp_flags = fl; exu_rsp_err = err;
         tick();
         exu_rsp_valid = 1'b0; exu_rsp_err = 1'b0;
         check(done_n == 1'b0, "R11 pulse low", {63'b0, done_n}, 64'h0);
         quit = err;
      end
      tick();
      check(done_n == 1'b1, "R11 pulse width", {63'b0, done_n}, 64'h1);
      est = 16'(quit);
      if (cmp) begin est[7] = fl[2]; est[6] = fl[1]; est[2] = fl[0]; end
      bus_read(4'b1110, rd);
      check(rd == est, quit ? "R9/R10 status" : {rq, "/R5/R11 status"}, 64'(rd), 64'(est));
      if (res && !quit) begin
         for (int w = 0; w < wpo; w++) begin
            bus_read(4'b1101, rd);
            check(rd == data[16*w +: 16], {rq, "/R8 result word"}, 64'(rd), 64'(data[16*w +: 16]));
         end
      end
      bus_read(4'b1101, rd);
      check(rd == 16'h0, {rq, "/R12 no extra result"}, 64'(rd), 64'h0);
   endtask

   initial begin
      logic [15:0] rd;
      void'($urandom(32'h5EED_0042));
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check(done_n == 1'b1 && exu_req_valid == 1'b0, "R11 reset state", {62'b0, done_n, exu_req_valid}, 64'h2);
      bus_read(4'b1110, rd);
      check(rd == 16'h0, "R12 idle read", 64'(rd), 64'h0);

      // R1: foreign id, then id with wrong tag
      bus_write(4'b1111, 16'h0033);
      bus_write(4'b1101, swap(16'h000F));
      tick();
      check(exu_req_valid == 1'b0 && done_n == 1'b1, "R1 foreign id", {62'b0, done_n, exu_req_valid}, 64'h2);
      bus_write(4'b1101, {8'h00, MY_ID});
      bus_write(4'b1101, swap(16'h000F));
      tick();
      check(exu_req_valid == 1'b0 && done_n == 1'b1, "R1 wrong tag", {62'b0, done_n, exu_req_valid}, 64'h2);

      // directed: every opcode under every type
      for (int t = 0; t < 4; t++)
         for (int o = 0; o < 16; o++)
            run_instr(o, t, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);
      // R10: error responses on result and compare instructions
      run_instr(0, 1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b1);
      run_instr(11, 0, 64'h10, 64'h20, 1'b1);
      run_instr(15, 1, 64'h0, 64'h0, 1'b1);
      // random mix
      for (int i = 0; i < 80; i++) begin
         int t;
         t = (($urandom % 8) == 0) ? 3 : int'($urandom % 3);
         run_instr(int'($urandom % 16), t, {$urandom, $urandom}, {$urandom, $urandom},
                   (($urandom % 10) == 0));
      end
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule